// File: doc/BRIEF.md
# Bus-Master Refresh Cycle Sequencer

This block sequences DRAM and expansion-bus refresh cycles. A cycle is requested either by a periodic tick from a refresh timer or by an add-on bus master that pulls an active-low refresh request line. For every cycle the block drives an active-low memory-read strobe and presents an 8-bit refresh row address. A bus master may hold its request low for much longer than one cycle. In that case the block repeats refresh cycles at a fixed row, and by default spaces their strobes at least one microsecond apart.

Timer-driven cycles can run hidden behind CPU activity. A hidden cycle takes its strobe width from a two-bit CPU speed code. A start-cycle pulse that arrives while a hidden cycle is in flight is held back and released once that cycle has ended. Cycles that run while the bus hold is acknowledged always use the fixed width. An enable input decides whether hidden cycles show up on the expansion-bus refresh and strobe outputs.

Top module: `ref_cycle_seq`

## Requirements
- R1: While rst_ni is low, memr_no and ref_no are 1, ref_addr_o is 0, and ref_done_o and start_o are 0.
- R2: With space_dis_i = 0, two master-requested strobes start at least CYC_US clocks apart while mst_ref_ni stays low. ref_no stays 1 during master cycles.
- R3: With space_dis_i = 1, master-requested strobes repeat every FIX_W + REC_W + 1 clocks while mst_ref_ni stays low.
- R4: While mst_ref_ni stays low, every master cycle presents the same ref_addr_o. The address advances by exactly one after the synchronized request has gone high.
- R5: A timer cycle with hidden_en_i = 0 holds memr_no low for FIX_W clocks and ref_no low for FIX_W + REC_W clocks. ref_addr_o then advances by one, modulo 256.
- R6: A hidden timer cycle (hidden_en_i = 1, hold_ack_i = 0) holds memr_no low for HID_W_FAST clocks when speed_sel_i = 2'b10. For 2'b01 and for the reserved codes 2'b00 and 2'b11 it holds memr_no low for HID_W_SLOW clocks.
- R7: A timer cycle started while hold_ack_i = 1 uses FIX_W, whatever speed_sel_i holds.
- R8: A hidden cycle with at_ref_en_i = 0 leaves memr_no and ref_no at 1. It still pulses ref_done_o and advances ref_addr_o.
- R9: A start_req_i pulse that meets a hidden cycle that is starting or running comes out on start_o exactly REC_W + 1 clocks after that cycle's ref_done_o, and is never asserted while the hidden cycle runs. At any other time start_o follows start_req_i one clock later.
- R10: ref_done_o goes high for exactly one clock, in the clock after the last strobe clock of every cycle.
- R11: mst_ref_ni passes through SYNC_N flops. The first master strobe goes low SYNC_N + 1 clocks after the request is first sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Refresh timer request pulse |
| mst_ref_ni | input | 1 | Bus-master refresh request, active low, asynchronous |
| hold_ack_i | input | 1 | Bus hold acknowledged; forces fixed timing |
| hidden_en_i | input | 1 | Run timer cycles as hidden refresh |
| at_ref_en_i | input | 1 | Show hidden cycles on ref_no and memr_no |
| space_dis_i | input | 1 | 1 removes the master strobe spacing |
| speed_sel_i | input | 2 | Hidden timing code: 01 slow, 10 fast, others as 01 |
| start_req_i | input | 1 | Start-cycle pulse from the CPU side |
| ref_no | output | 1 | Refresh request driven for timer cycles, active low |
| memr_no | output | 1 | Memory-read strobe, active low |
| ref_addr_o | output | 8 | Refresh row address |
| ref_done_o | output | 1 | One-clock pulse after every strobe |
| start_o | output | 1 | Start-cycle pulse, delayed past hidden cycles |

## Verification
The assertions watch, on every clock, the minimum spacing between master strobes, that the row address holds while the strobe is low, that start_o stays low during a hidden cycle, that ref_done_o lasts one clock, and that ref_no stays high during master cycles. Strobe widths per speed code, the fallback of the reserved codes, the hold-acknowledge override, the suppression of outputs when the bus enable is off, the single address step after a master releases its request, wrap-around, the synchronizer latency and the exact release time of a held start pulse can only be shown by the bench's scenarios.

// File: rtl/ref_seq_pkg.sv
package ref_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STROBE  = 2'd1,
    ST_RECOVER = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    SPD_RSV_LO = 2'b00,
    SPD_SLOW   = 2'b01,
    SPD_FAST   = 2'b10,
    SPD_RSV_HI = 2'b11
  } speed_e;

  // reserved codes fall back to the slow timing
  function automatic int hid_width(logic [1:0] code, int slow_w, int fast_w);
    return (code == SPD_FAST) ? fast_w : slow_w;
  endfunction

endpackage

// File: rtl/ref_sync.sv
module ref_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= RST_VAL;
        else         ff_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= RST_VAL;
        else         ff_q[g] <= ff_q[g-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/ref_space_timer.sv
module ref_space_timer #(
  parameter int CYC_US = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ok_o
);

  localparam int SW = $clog2(CYC_US + 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= SW'(CYC_US - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q == '0);

endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (inc_i) addr_o <= addr_o + 1'b1;
  end

endmodule

// File: rtl/ref_cycle_seq.sv
module ref_cycle_seq
  import ref_seq_pkg::*;
#(
  parameter int CYC_US     = 16,
  parameter int FIX_W      = 4,
  parameter int HID_W_SLOW = 2,
  parameter int HID_W_FAST = 3,
  parameter int REC_W      = 2,
  parameter int SYNC_N     = 2,
  parameter int AW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          mst_ref_ni,
  input  logic          hold_ack_i,
  input  logic          hidden_en_i,
  input  logic          at_ref_en_i,
  input  logic          space_dis_i,
  input  logic [1:0]    speed_sel_i,
  input  logic          start_req_i,
  output logic          ref_no,
  output logic          memr_no,
  output logic [AW-1:0] ref_addr_o,
  output logic          ref_done_o,
  output logic          start_o
);

  localparam int MAXW_A = (FIX_W > REC_W) ? FIX_W : REC_W;
  localparam int MAXW_B = (HID_W_SLOW > HID_W_FAST) ? HID_W_SLOW : HID_W_FAST;
  localparam int MAXW   = (MAXW_A > MAXW_B) ? MAXW_A : MAXW_B;
  localparam int CW     = $clog2(MAXW + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          cyc_mst_q, cyc_hid_q, cyc_drv_q;
  logic          tmr_pend_q, burst_q, start_pend_q;
  logic          mst_sync, mst_req, space_ok;
  logic          mst_go, tmr_go, go_hid, hid_go, hid_busy;
  logic          strobe_end, rec_end, burst_rel, addr_inc;
  int            tmr_w;

  ref_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mst_ref_ni),
    .q_o   (mst_sync)
  );

  assign mst_req = ~mst_sync;

  ref_space_timer #(.CYC_US(CYC_US)) u_space (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(mst_go),
    .ok_o  (space_ok)
  );

  ref_row_ctr #(.AW(AW)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (addr_inc),
    .addr_o(ref_addr_o)
  );

  always_comb begin
    go_hid     = hidden_en_i && !hold_ack_i;
    tmr_w      = go_hid ? hid_width(speed_sel_i, HID_W_SLOW, HID_W_FAST) : FIX_W;
    mst_go     = (state_q == ST_IDLE) && mst_req && (space_ok || space_dis_i);
    tmr_go     = (state_q == ST_IDLE) && tmr_pend_q && !mst_req && !burst_q;
    hid_go     = tmr_go && go_hid;
    hid_busy   = (state_q != ST_IDLE) && cyc_hid_q;
    strobe_end = (state_q == ST_STROBE) && (cnt_q == '0);
    rec_end    = (state_q == ST_RECOVER) && (cnt_q == '0);
    burst_rel  = (state_q == ST_IDLE) && burst_q && !mst_req;
    addr_inc   = (strobe_end && !cyc_mst_q) || burst_rel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      cyc_mst_q <= 1'b0;
      cyc_hid_q <= 1'b0;
      cyc_drv_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (mst_go) begin
            state_q   <= ST_STROBE;
            cnt_q     <= CW'(FIX_W - 1);
            cyc_mst_q <= 1'b1;
            cyc_hid_q <= 1'b0;
            cyc_drv_q <= 1'b1;
          end else if (tmr_go) begin
            state_q   <= ST_STROBE;
            cnt_q     <= CW'(tmr_w - 1);
            cyc_mst_q <= 1'b0;
            cyc_hid_q <= go_hid;
            cyc_drv_q <= !go_hid || at_ref_en_i;
          end
        end
        ST_STROBE: begin
          if (strobe_end) begin
            state_q <= ST_RECOVER;
            cnt_q   <= CW'(REC_W - 1);
          end else begin
            cnt_q   <= cnt_q - 1'b1;
          end
        end
        ST_RECOVER: begin
          if (rec_end) state_q <= ST_IDLE;
          else         cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_pend_q   <= 1'b0;
      burst_q      <= 1'b0;
      start_pend_q <= 1'b0;
      start_o      <= 1'b0;
      ref_done_o   <= 1'b0;
    end else begin
      tmr_pend_q   <= tick_i || (tmr_pend_q && !tmr_go);
      if (mst_go)         burst_q <= 1'b1;
      else if (burst_rel) burst_q <= 1'b0;
      // start pulse is held while a hidden cycle is starting or running
      start_pend_q <= (start_req_i || start_pend_q) && (hid_busy || hid_go);
      start_o      <= (start_req_i || start_pend_q) && !hid_busy && !hid_go;
      ref_done_o   <= strobe_end;
    end
  end

  assign memr_no = !((state_q == ST_STROBE) && cyc_drv_q);
  assign ref_no  = !((state_q != ST_IDLE) && !cyc_mst_q && cyc_drv_q);

endmodule

// File: rtl/ref_cycle_seq_chk.sv
module ref_cycle_seq_chk #(
  parameter int CYC_US = 16,
  parameter int AW     = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          memr_no,
  input logic          ref_no,
  input logic [AW-1:0] ref_addr_o,
  input logic          ref_done_o,
  input logic          start_o,
  input logic          space_dis_i,
  input logic          cyc_mst,
  input logic          hid_busy,
  input logic          mst_go
);

  localparam int GW = $clog2(CYC_US + 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (mst_go) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q < GW'(CYC_US)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  a_r2_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_go && seen_q && !space_dis_i) |-> (gap_q >= GW'(CYC_US)));

  a_r2_mst_no_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_mst && !memr_no) |-> ref_no);

  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!memr_no && !$past(memr_no)) |-> $stable(ref_addr_o));

  a_r9_start_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hid_busy |-> !start_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |=> !ref_done_o);

  a_r10_done_strobe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |-> memr_no);

endmodule

bind ref_cycle_seq ref_cycle_seq_chk #(.CYC_US(CYC_US), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .memr_no    (memr_no),
  .ref_no     (ref_no),
  .ref_addr_o (ref_addr_o),
  .ref_done_o (ref_done_o),
  .start_o    (start_o),
  .space_dis_i(space_dis_i),
  .cyc_mst    (cyc_mst_q),
  .hid_busy   (hid_busy),
  .mst_go     (mst_go)
);

// File: tb/tb_ref_cycle_seq.sv
module tb_ref_cycle_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CYC_US     = 16;
  localparam int FIX_W      = 4;
  localparam int HID_W_SLOW = 2;
  localparam int HID_W_FAST = 3;
  localparam int REC_W      = 2;
  localparam int SYNC_N     = 2;
  localparam int AW         = 8;
  localparam int AMASK      = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, mst_ref_n = 1'b1, hold_ack = 1'b0, hidden_en = 1'b0;
  logic at_ref_en = 1'b1, space_dis = 1'b0, start_req = 1'b0;
  logic [1:0] speed = 2'b01;
  logic ref_n, memr_n, ref_done, start;
  logic [AW-1:0] ref_addr;

  ref_cycle_seq #(
    .CYC_US(CYC_US), .FIX_W(FIX_W), .HID_W_SLOW(HID_W_SLOW), .HID_W_FAST(HID_W_FAST),
    .REC_W(REC_W), .SYNC_N(SYNC_N), .AW(AW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mst_ref_ni(mst_ref_n),
    .hold_ack_i(hold_ack), .hidden_en_i(hidden_en), .at_ref_en_i(at_ref_en),
    .space_dis_i(space_dis), .speed_sel_i(speed), .start_req_i(start_req),
    .ref_no(ref_n), .memr_no(memr_n), .ref_addr_o(ref_addr),
    .ref_done_o(ref_done), .start_o(start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int n_fall = 0, last_fall = 0, min_gap = 1000000, last_w = 0, low_cnt = 0;
  int ref_low = 0, n_done = 0, done_cyc = 0, n_start = 0, start_cyc = 0;
  int first_addr = 0, addr_bad = 0, exp_addr = 0;
  logic memr_prev = 1'b1;

  // output monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!memr_n) begin
      low_cnt++;
      if (memr_prev) begin
        if (n_fall > 0 && (cyc - last_fall) < min_gap) min_gap = cyc - last_fall;
        if (n_fall == 0) first_addr = int'(ref_addr);
        else if (int'(ref_addr) != first_addr) addr_bad = 1;
        n_fall++;
        last_fall = cyc;
      end
    end else if (!memr_prev) begin
      last_w  = low_cnt;
      low_cnt = 0;
    end
    memr_prev = memr_n;
    if (!ref_n) ref_low++;
    if (ref_done) begin n_done++; done_cyc = cyc; end
    if (start)    begin n_start++; start_cyc = cyc; end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic clr();
    n_fall = 0; min_gap = 1000000; ref_low = 0; n_done = 0; n_start = 0;
    addr_bad = 0; low_cnt = 0; last_w = 0;
  endtask

  task automatic check(bit ok, string rq, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_w(bit hid, bit hold, logic [1:0] spd);
    if (!hid || hold) return FIX_W;
    return (spd == 2'b10) ? HID_W_FAST : HID_W_SLOW;
  endfunction

  task automatic run_timer(bit hid, bit hold, bit atr, logic [1:0] spd);
    bit drive;
    int w;
    string rq;
    drive = !hid || hold || atr;
    w     = exp_w(hid, hold, spd);
    rq    = !drive ? "R8" : (hid && hold) ? "R7" : hid ? "R6" : "R5";
    hidden_en = hid; hold_ack = hold; at_ref_en = atr; speed = spd;
    clr();
    tick = 1'b1; step(); tick = 1'b0;
    step(FIX_W + REC_W + 4);
    exp_addr = (exp_addr + 1) & AMASK;
    check(int'(ref_addr) == exp_addr, rq, "address step", int'(ref_addr), exp_addr);
    check(n_done == 1, "R10", "done pulses", n_done, 1);
    if (drive) begin
      check(last_w == w, rq, "strobe width", last_w, w);
      check(ref_low == w + REC_W, rq, "ref low clocks", ref_low, w + REC_W);
    end else begin
      check(n_fall == 0, "R8", "strobes", n_fall, 0);
      check(ref_low == 0, "R8", "ref low clocks", ref_low, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL all watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0, a0;
    void'($urandom(32'h5EED_0042));
    step(3);
    // R1 reset state
    check(memr_n == 1'b1, "R1", "memr_no", int'(memr_n), 1);
    check(ref_n == 1'b1, "R1", "ref_no", int'(ref_n), 1);
    check(ref_addr == '0, "R1", "addr", int'(ref_addr), 0);
    check(ref_done == 1'b0 && start == 1'b0, "R1", "done|start", int'(ref_done | start), 0);
    rst_n = 1'b1;
    step(2);

    // R5 plain timer cycle
    run_timer(1'b0, 1'b0, 1'b1, 2'b01);
    // R6 all speed codes
    run_timer(1'b1, 1'b0, 1'b1, 2'b01);
    run_timer(1'b1, 1'b0, 1'b1, 2'b10);
    run_timer(1'b1, 1'b0, 1'b1, 2'b00);
    run_timer(1'b1, 1'b0, 1'b1, 2'b11);
    // R7 hold acknowledge overrides speed code
    run_timer(1'b1, 1'b1, 1'b1, 2'b10);
    run_timer(1'b1, 1'b1, 1'b1, 2'b01);
    // R8 hidden with bus refresh disabled
    run_timer(1'b1, 1'b0, 1'b0, 2'b10);
    hidden_en = 1'b0; hold_ack = 1'b0; at_ref_en = 1'b1;

    // R11 latency, R2 spacing, R4 fixed address
    space_dis = 1'b0;
    clr();
    a0 = exp_addr;
    c0 = cyc;
    mst_ref_n = 1'b0;
    step(SYNC_N + 1);
    check(n_fall == 1 && last_fall == c0 + SYNC_N + 1, "R11", "first strobe cycle",
          last_fall - c0, SYNC_N + 1);
    step(80);
    check(n_fall >= 4, "R2", "strobe count", n_fall, 4);
    check(min_gap >= CYC_US, "R2", "min spacing", min_gap, CYC_US);
    check(ref_low == 0, "R2", "ref low during master", ref_low, 0);
    check(addr_bad == 0 && first_addr == a0, "R4", "burst address", first_addr, a0);
    mst_ref_n = 1'b1;
    step(14);
    exp_addr = (exp_addr + 1) & AMASK;
    check(int'(ref_addr) == exp_addr, "R4", "address after release", int'(ref_addr), exp_addr);

    // R3 spacing disabled
    space_dis = 1'b1;
    clr();
    mst_ref_n = 1'b0;
    step(SYNC_N + 61);
    check(min_gap == FIX_W + REC_W + 1, "R3", "back-to-back period", min_gap, FIX_W + REC_W + 1);
    check(addr_bad == 0, "R4", "address fixed without spacing", addr_bad, 0);
    mst_ref_n = 1'b1;
    step(14);
    exp_addr = (exp_addr + 1) & AMASK;
    check(int'(ref_addr) == exp_addr, "R4", "address after release", int'(ref_addr), exp_addr);
    space_dis = 1'b0;

    // R9 start pulse held across hidden cycle
    hidden_en = 1'b1; at_ref_en = 1'b1; speed = 2'b01;
    clr();
    tick = 1'b1; step(); tick = 1'b0;
    step();
    start_req = 1'b1; step(); start_req = 1'b0;
    step(10);
    exp_addr = (exp_addr + 1) & AMASK;
    check(n_start == 1, "R9", "held start count", n_start, 1);
    check(start_cyc == done_cyc + REC_W + 1, "R9", "held start delay",
          start_cyc - done_cyc, REC_W + 1);

    // R9 no hidden cycle: one clock delay
    hidden_en = 1'b0;
    clr();
    c0 = cyc;
    start_req = 1'b1; step(); start_req = 1'b0;
    check(n_start == 1 && start_cyc == c0 + 1, "R9", "direct start delay", start_cyc - c0, 1);
    step(3);

    // random timer cycles, wraps the address (R5)
    for (int i = 0; i < 300; i++) begin
      run_timer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule